// File: doc/BRIEF.md
# BCD Clock-Calendar Counter Chain

This block keeps wall-clock time and calendar date as a chain of packed-BCD counters: seconds, minutes, hours, day of week, day of month, month, two-digit year, plus a century flag packed into the hours byte. A prescaler supplies a sub-second enable pulse (`sub_tick`). An internal phase counter turns every `SUBTICKS_PER_SEC` of those pulses into one step of the seconds counter. Month lengths follow the calendar, and February gains its 29th day in leap years.

A bus front end reads and writes eight byte-wide registers. Addresses 0 to 6 are the time fields and address 7 is an independent control byte. The block keeps two copies of the time. The running copy always counts. The visible copy is what the bus reads. While the front end reports that a clock register read is in progress, the visible copy is frozen for at most a quarter of a second. It then catches up with the running copy in a single cycle, so a burst read never returns a torn snapshot and no time is lost.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the registers read: address 0 = 0x00, address 1 = 0x00, address 2 = 0x00, address 3 = 0x01, address 4 = 0x01, address 5 = 0x01, address 6 = 0x00, address 7 = 0x80. `running` reads 1.
- R2: Seconds (address 0, bits 6:0), minutes (address 1, bits 6:0) and hours (address 2, bits 5:0) count in BCD.
  - Seconds and minutes wrap from 0x59 to 0x00. Hours wrap from 0x23 to 0x00.
  - Each wrap carries into the next field.
  - One second passes per `SUBTICKS_PER_SEC` sub_tick pulses, counted from the last write to address 0.
- R3: At midnight the date (address 4, bits 5:0) advances.
  - Past the month's last day, the date returns to 0x01 and the month (address 5, bits 4:0) advances.
  - Month 0x12 wraps to 0x01 and advances the year (address 6, 0x99 wraps to 0x00).
  - Months 04, 06, 09 and 11 have 30 days. The other months, apart from February, have 31.
- R4: February has 29 days when the two-digit year is a multiple of 4 (00 included) and 28 days otherwise.
- R5: The day of week (address 3, bits 2:0) advances at midnight and wraps from 7 to 1.
- R6: Bit 7 of address 2 is the century enable and bit 6 is the century flag. When the year wraps from 99 to 00, the flag inverts if the enable is 1 and holds if the enable is 0.
- R7: Bit 7 of address 0 is the stop flag.
  - While it is 1, no time field advances and `running` is 0.
  - After a write that clears it, the next second step comes exactly `SUBTICKS_PER_SEC` sub_tick pulses later.
- R8: Bits that carry no field read back as 0: address 1 bit 7, address 3 bits 7:3, address 4 bits 7:6, address 5 bits 7:5.
- R9: While `rd_active` is 1 and fewer than `SUBTICKS_PER_SEC/4` sub_tick pulses have passed since it rose, reads of addresses 0 to 6 return frozen values. The running time keeps counting. When the hold ends, all visible fields take the running values in one cycle.
- R10: If `rd_active` stays 1 for `SUBTICKS_PER_SEC/4` sub_tick pulses, the hold is released and the visible fields track the running time again, even with `rd_active` still 1.
- R11: A write to addresses 0 to 6 loads both copies. It reads back on the next cycle even while the visible copy is held.
- R12: Address 7 stores all eight written bits. It is unaffected by time steps, by stop and by the read hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_tick | input | 1 | One-cycle sub-second enable from the prescaler |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational from stored state) |
| rd_active | input | 1 | A clock-register read burst is in progress |
| running | output | 1 | 1 while the stop flag is clear |

## Verification
On every cycle, the embedded properties check several things:
- the seconds, day-of-week, February and century carries of the running chain;
- the freezing of the whole running copy under the stop flag;
- the frozen visible copy during a hold and the one-cycle catch-up afterwards;
- immediate visibility of writes and the isolation of the control byte.

Month-length tables over many dates, the exact sub-tick count of the hold window, and the fact that the running time kept counting while the view was frozen can only be shown by the bench's directed and randomized scenarios, which compare every readable field against a calendar model.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int NUM_TIME_REGS = 7;
   localparam int REG_AW        = 3;

   localparam int AD_SEC  = 0;
   localparam int AD_MIN  = 1;
   localparam int AD_HR   = 2;
   localparam int AD_DOW  = 3;
   localparam int AD_DATE = 4;
   localparam int AD_MON  = 5;
   localparam int AD_YR   = 6;
   localparam logic [REG_AW-1:0] AD_CTL = 3'd7;

   typedef logic [NUM_TIME_REGS-1:0][7:0] time_bank_t;

   // index 6 (year) first
   localparam time_bank_t TIME_RST = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

   // bits that hold a field, per address
   function automatic logic [7:0] field_mask(input logic [REG_AW-1:0] a);
      case (a)
         3'd0:    return 8'hFF;
         3'd1:    return 8'h7F;
         3'd2:    return 8'hFF;
         3'd3:    return 8'h07;
         3'd4:    return 8'h3F;
         3'd5:    return 8'h1F;
         default: return 8'hFF;
      endcase
   endfunction

   // plain BCD increment, no range limit
   function automatic logic [7:0] bcd_next(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // year multiple of 4: even tens -> units 0/4/8, odd tens -> units 2/6
   function automatic logic is_leap(input logic [7:0] yr);
      if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
      return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
   endfunction

   // last day of month in BCD
   function automatic logic [5:0] month_days(input logic [4:0] mon, input logic [7:0] yr);
      case (mon)
         5'h02:                      return is_leap(yr) ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
         default:                    return 6'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_subsec_div.sv
module rtc_subsec_div #(
   parameter int TICKS = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sub_tick,
   input  logic halt,
   input  logic phase_clr,
   output logic sec_pulse
);
   localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

   logic [CW-1:0] phase_q;

   assign sec_pulse = sub_tick && !halt && !phase_clr && (phase_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                phase_q <= '0;
      else if (phase_clr || halt) phase_q <= '0;
      else if (sub_tick)          phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
   end

   // R7: a halted divider produces no second step and keeps phase zero
   a_r7_halt_phase: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> (phase_q == '0));

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
   import rtc_cal_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_pulse,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output time_bank_t        run_q
);
   logic       sec_w, min_w, hr_w, date_w, mon_w, yr_w;
   logic       day_roll, yr_roll;
   logic [5:0] mlen;
   logic [7:0] inc_sec, inc_min, inc_hr, inc_date, inc_mon, inc_yr;
   time_bank_t adv, nxt;

   always_comb begin
      mlen     = month_days(run_q[AD_MON][4:0], run_q[AD_YR]);
      sec_w    = run_q[AD_SEC][6:0]  == 7'h59;
      min_w    = run_q[AD_MIN][6:0]  == 7'h59;
      hr_w     = run_q[AD_HR][5:0]   == 6'h23;
      date_w   = run_q[AD_DATE][5:0] >= mlen;
      mon_w    = run_q[AD_MON][4:0]  >= 5'h12;
      yr_w     = run_q[AD_YR]        == 8'h99;
      day_roll = sec_w && min_w && hr_w;
      yr_roll  = day_roll && date_w && mon_w && yr_w;
      inc_sec  = bcd_next({1'b0, run_q[AD_SEC][6:0]});
      inc_min  = bcd_next({1'b0, run_q[AD_MIN][6:0]});
      inc_hr   = bcd_next({2'b0, run_q[AD_HR][5:0]});
      inc_date = bcd_next({2'b0, run_q[AD_DATE][5:0]});
      inc_mon  = bcd_next({3'b0, run_q[AD_MON][4:0]});
      inc_yr   = bcd_next(run_q[AD_YR]);

      adv = run_q;
      if (sec_pulse) begin
         adv[AD_SEC][6:0] = sec_w ? 7'h00 : inc_sec[6:0];
         if (sec_w) begin
            adv[AD_MIN][6:0] = min_w ? 7'h00 : inc_min[6:0];
            if (min_w) begin
               adv[AD_HR][5:0] = hr_w ? 6'h00 : inc_hr[5:0];
               if (hr_w) begin
                  adv[AD_DOW][2:0]  = (run_q[AD_DOW][2:0] >= 3'd7) ? 3'd1
                                                                  : run_q[AD_DOW][2:0] + 3'd1;
                  adv[AD_DATE][5:0] = date_w ? 6'h01 : inc_date[5:0];
                  if (date_w) begin
                     adv[AD_MON][4:0] = mon_w ? 5'h01 : inc_mon[4:0];
                     if (mon_w) begin
                        adv[AD_YR] = yr_w ? 8'h00 : inc_yr;
                        if (yr_w && run_q[AD_HR][7])
                           adv[AD_HR][6] = ~run_q[AD_HR][6];
                     end
                  end
               end
            end
         end
      end

      nxt = adv;
      if (wr_en && (wr_addr != AD_CTL))
         nxt[wr_addr] = wr_data & field_mask(wr_addr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= TIME_RST;
      else        run_q <= nxt;
   end

   // R2: seconds wrap from 59 to 00
   a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_pulse && !wr_en && sec_w) |=> (run_q[AD_SEC][6:0] == 7'h00));

   // R5: day of week wraps 7 -> 1 at midnight
   a_r5_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_pulse && !wr_en && day_roll && run_q[AD_DOW][2:0] == 3'd7)
      |=> (run_q[AD_DOW][2:0] == 3'd1));

   // R4: Feb 28 of a year divisible by 4 goes to Feb 29
   a_r4_feb_leap: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_pulse && !wr_en && day_roll && run_q[AD_MON][4:0] == 5'h02 &&
       run_q[AD_DATE][5:0] == 6'h28 && run_q[AD_YR] == 8'h24)
      |=> (run_q[AD_DATE][5:0] == 6'h29 && run_q[AD_MON][4:0] == 5'h02));

   // R6: century flag inverts only when enabled
   a_r6_century: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_pulse && !wr_en && yr_roll)
      |=> (run_q[AD_HR][6] == ($past(run_q[AD_HR][6]) ^ $past(run_q[AD_HR][7]))));

endmodule

// File: rtl/rtc_view_hold.sv
module rtc_view_hold
   import rtc_cal_pkg::*;
#(
   parameter int HOLD_TICKS = 64,
   parameter bit DEFER_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sub_tick,
   input  logic              rd_active,
   input  time_bank_t        run_q,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output time_bank_t        vis_q
);
   logic hold;
   logic wr_time;

   assign wr_time = wr_en && (wr_addr != AD_CTL);

   generate
      if (DEFER_EN) begin : g_defer
         localparam int HW = $clog2(HOLD_TICKS + 1);
         localparam logic [HW-1:0] LIM = HW'(HOLD_TICKS);
         logic [HW-1:0] hold_cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      hold_cnt_q <= '0;
            else if (!rd_active)             hold_cnt_q <= '0;
            else if (sub_tick && hold_cnt_q != LIM) hold_cnt_q <= hold_cnt_q + 1'b1;
         end

         assign hold = rd_active && (hold_cnt_q != LIM);
      end else begin : g_direct
         assign hold = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vis_q <= TIME_RST;
      end else begin
         if (!hold) vis_q <= run_q;
         if (wr_time) vis_q[wr_addr] <= wr_data & field_mask(wr_addr);
      end
   end

   // R9: held view does not move
   a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !wr_time) |=> $stable(vis_q));

   // R9: released view equals the running copy of the previous cycle, all fields at once
   a_r9_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !wr_time) |=> (vis_q == $past(run_q)));

   // R11: a write is visible on the next cycle, hold or not
   a_r11_write_seen: assert property (@(posedge clk) disable iff (!rst_n)
      wr_time |=> (vis_q[$past(wr_addr)] == ($past(wr_data) & field_mask($past(wr_addr)))));

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
   import rtc_cal_pkg::*;
#(
   parameter int          SUBTICKS_PER_SEC = 256,
   parameter bit          DEFER_EN         = 1'b1,
   parameter logic [7:0]  CTL_RST          = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sub_tick,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              rd_active,
   output logic              running
);
   localparam int HOLD_TICKS = SUBTICKS_PER_SEC / 4;

   initial begin
      assert (SUBTICKS_PER_SEC >= 4 && (SUBTICKS_PER_SEC % 4) == 0)
         else $error("SUBTICKS_PER_SEC must be a multiple of 4, at least 4");
   end

   time_bank_t run_q, vis_q;
   logic       sec_pulse;
   logic       stopped;
   logic [7:0] ctl_q;

   assign stopped = run_q[AD_SEC][7];
   assign running = !stopped;

   rtc_subsec_div #(.TICKS(SUBTICKS_PER_SEC)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .sub_tick  (sub_tick),
      .halt      (stopped),
      .phase_clr (reg_wr && reg_addr == 3'd0),
      .sec_pulse (sec_pulse)
   );

   rtc_time_chain u_chain (
      .clk       (clk),
      .rst_n     (rst_n),
      .sec_pulse (sec_pulse),
      .wr_en     (reg_wr),
      .wr_addr   (reg_addr),
      .wr_data   (reg_wdata),
      .run_q     (run_q)
   );

   rtc_view_hold #(.HOLD_TICKS(HOLD_TICKS), .DEFER_EN(DEFER_EN)) u_view (
      .clk       (clk),
      .rst_n     (rst_n),
      .sub_tick  (sub_tick),
      .rd_active (rd_active),
      .run_q     (run_q),
      .wr_en     (reg_wr),
      .wr_addr   (reg_addr),
      .wr_data   (reg_wdata),
      .vis_q     (vis_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ctl_q <= CTL_RST;
      else if (reg_wr && reg_addr == AD_CTL) ctl_q <= reg_wdata;
   end

   assign reg_rdata = (reg_addr == AD_CTL) ? ctl_q : vis_q[reg_addr];

   // R7: with the stop flag set and no write, the running time stays put
   a_r7_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (stopped && !reg_wr) |=> $stable(run_q));

   // R12: control byte moves only on its own write
   a_r12_ctl_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == AD_CTL) |=> $stable(ctl_q));

endmodule

// File: tb/rtc_calendar_core_bench.sv
`timescale 1ns/1ps
module rtc_calendar_core_bench;
   localparam int SUB = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sub_tick = 1'b0;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       rd_active = 1'b0;
   logic       running;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // calendar model (binary)
   int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr, m_ce, m_cb, m_st;

   always #2.5 clk = ~clk;

   rtc_calendar_core #(.SUBTICKS_PER_SEC(SUB)) u_rtc_calendar_core (
      .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rd_active(rd_active), .running(running)
   );

   function automatic int bcd(input int v);
      return ((v / 10) << 4) | (v % 10);
   endfunction

   function automatic int mlen(input int m, input int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   function automatic logic [7:0] exp_reg(input int a);
      case (a)
         0: return 8'((m_st << 7) | bcd(m_sec));
         1: return 8'(bcd(m_min));
         2: return 8'((m_ce << 7) | (m_cb << 6) | bcd(m_hr));
         3: return 8'(m_dow);
         4: return 8'(bcd(m_date));
         5: return 8'(bcd(m_mon));
         default: return 8'(bcd(m_yr));
      endcase
   endfunction

   task automatic model_step();
      if (m_st != 0) return;
      m_sec++;
      if (m_sec < 60) return;
      m_sec = 0; m_min++;
      if (m_min < 60) return;
      m_min = 0; m_hr++;
      if (m_hr < 24) return;
      m_hr = 0;
      m_dow = (m_dow == 7) ? 1 : m_dow + 1;
      m_date++;
      if (m_date <= mlen(m_mon, m_yr)) return;
      m_date = 1; m_mon++;
      if (m_mon <= 12) return;
      m_mon = 1; m_yr++;
      if (m_yr <= 99) return;
      m_yr = 0;
      if (m_ce != 0) m_cb = 1 - m_cb;
   endtask

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got 0x%02h expected 0x%02h", req, got, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = 3'(a);
      #1 d = reg_rdata;
   endtask

   task automatic pulses(input int n);
      repeat (n) begin
         @(negedge clk); sub_tick = 1'b1;
         @(negedge clk); sub_tick = 1'b0;
      end
   endtask

   task automatic seconds(input int k);
      pulses(SUB * k);
      repeat (k) model_step();
      idle(2);
   endtask

   task automatic check_all(input string req);
      logic [7:0] d;
      for (int a = 0; a < 7; a++) begin
         rd(a, d);
         check(req, d, exp_reg(a));
      end
   endtask

   task automatic set_time(input int y, input int mo, input int da, input int dw,
                           input int h, input int mi, input int s, input int ce, input int cb);
      m_yr = y; m_mon = mo; m_date = da; m_dow = dw; m_hr = h; m_min = mi; m_sec = s;
      m_ce = ce; m_cb = cb; m_st = 0;
      wr(6, bcd(y)); wr(5, bcd(mo)); wr(4, bcd(da)); wr(3, dw);
      wr(2, (ce << 7) | (cb << 6) | bcd(h)); wr(1, bcd(mi));
      wr(0, bcd(s));
      idle(1);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'h5EED_2024));
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset values
      m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0;
      m_ce = 0; m_cb = 0; m_st = 0;
      check_all("R1");
      rd(7, d); check("R1 ctl", d, 8'h80);
      check("R1 running", {7'd0, running}, 8'h01);

      // R2 carries through seconds/minutes/hours
      set_time(10, 6, 14, 3, 13, 59, 58, 0, 0);
      seconds(1); check_all("R2 sec");
      seconds(1); check_all("R2 min/hr carry");
      set_time(10, 6, 14, 3, 9, 59, 59, 0, 0);
      seconds(1); check_all("R2 hr tens");

      // R3 month lengths
      set_time(21, 4, 30, 2, 23, 59, 59, 0, 0); seconds(1); check_all("R3 apr30");
      set_time(21, 1, 31, 2, 23, 59, 59, 0, 0); seconds(1); check_all("R3 jan31");
      set_time(21, 11, 30, 6, 23, 59, 59, 0, 0); seconds(1); check_all("R3 nov30");

      // R4 leap years
      set_time(24, 2, 28, 3, 23, 59, 59, 0, 0); seconds(1); check_all("R4 24 feb28");
      seconds(SUB * 0 + 1); check_all("R4 tick");
      set_time(24, 2, 29, 4, 23, 59, 59, 0, 0); seconds(1); check_all("R4 24 feb29");
      set_time(23, 2, 28, 2, 23, 59, 59, 0, 0); seconds(1); check_all("R4 23 feb28");
      set_time(0, 2, 28, 1, 23, 59, 59, 0, 0);  seconds(1); check_all("R4 00 feb28");

      // R5 day-of-week wrap
      set_time(5, 3, 10, 7, 23, 59, 59, 0, 0); seconds(1); check_all("R5 dow");

      // R6 century flag
      set_time(99, 12, 31, 7, 23, 59, 59, 1, 1); seconds(1); check_all("R6 enabled");
      set_time(99, 12, 31, 7, 23, 59, 59, 0, 1); seconds(1); check_all("R6 disabled");

      // R8 unused bits read zero
      wr(1, 8'hFF); rd(1, d); check("R8 min", d, 8'h7F);
      wr(3, 8'hFF); rd(3, d); check("R8 dow", d, 8'h07);
      wr(4, 8'hFF); rd(4, d); check("R8 date", d, 8'h3F);
      wr(5, 8'hFF); rd(5, d); check("R8 mon", d, 8'h1F);

      // R7 stop
      set_time(12, 5, 5, 5, 8, 30, 10, 0, 0);
      wr(0, 8'h90); m_st = 1;
      pulses(20); idle(2);
      check_all("R7 stopped");
      check("R7 running low", {7'd0, running}, 8'h00);
      wr(0, 8'h10); m_st = 0;
      pulses(SUB - 1); idle(2);
      check_all("R7 not yet");
      check("R7 running high", {7'd0, running}, 8'h01);
      pulses(1); model_step(); idle(2);
      check_all("R7 resumed");

      // R9 hold then single-cycle release
      set_time(12, 5, 5, 5, 12, 34, 56, 0, 0);
      pulses(SUB - 1);
      @(negedge clk); rd_active = 1'b1;
      pulses(1); idle(2);
      check_all("R9 held");
      @(negedge clk); rd_active = 1'b0;
      model_step(); idle(2);
      check_all("R9 released");

      // R10 bounded hold
      @(negedge clk); rd_active = 1'b1;
      seconds(1);
      check_all("R10 bounded");
      @(negedge clk); rd_active = 1'b0;
      idle(2);

      // R11 write during hold
      @(negedge clk); rd_active = 1'b1;
      wr(1, 8'h45); m_min = 45;
      rd(1, d); check("R11 held write", d, 8'h45);
      @(negedge clk); rd_active = 1'b0;
      idle(2);
      check_all("R11 after");

      // R12 control byte
      wr(7, 8'h5A);
      rd(7, d); check("R12 write", d, 8'h5A);
      seconds(2);
      @(negedge clk); rd_active = 1'b1;
      rd(7, d); check("R12 hold", d, 8'h5A);
      @(negedge clk); rd_active = 1'b0;
      wr(0, 8'h80 | bcd(m_sec)); m_st = 1;
      rd(7, d); check("R12 stop", d, 8'h5A);
      wr(0, bcd(m_sec)); m_st = 0;

      // random near-rollover dates (R2 R3 R4 R5 R6)
      for (int i = 0; i < 40; i++) begin
         int y, mo, da, h, mi, s, k;
         y  = int'($urandom % 100);
         mo = 1 + int'($urandom % 12);
         da = ($urandom % 2) ? mlen(mo, y) : 1 + int'($urandom % mlen(mo, y));
         h  = ($urandom % 2) ? 23 : int'($urandom % 24);
         mi = ($urandom % 4) ? 59 : int'($urandom % 60);
         s  = ($urandom % 4) ? 58 + int'($urandom % 2) : int'($urandom % 60);
         k  = 1 + int'($urandom % 2);
         set_time(y, mo, da, 1 + int'($urandom % 7), h, mi, s,
                  int'($urandom % 2), int'($urandom % 2));
         seconds(k);
         check_all("R3 R4 random");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule